// File: doc/BRIEF.md
# Programmable Parallel Port Core

This block gives an 8-bit processor bus three parallel ports, 24 lines in all, whose direction is set by software. Port A and port B are whole bytes. Port C is split into an upper and a lower nibble. The upper nibble goes with port A as group A, and the lower nibble goes with port B as group B. Every line has its own output latch, a live input, and an output-enable pin. A pad ring or a tristate wrapper outside the block combines these into a bidirectional line.

The block is reached through active-low chip select, read and write strobes, a 2-bit register select, and a data bus that is split into an input, an output and an output enable. One control address carries two commands, told apart by the top data bit. A mode command sets directions and group modes, and it clears every output latch. A single-bit command sets or clears one port C line. Only basic unstrobed I/O is carried out. The strobed and bidirectional group modes are stored and reported on output pins, but they add no handshake.

All bus strobes are sampled on `clk`. A write takes effect on the clock edge where the write strobe is first seen high again, using the select and data captured while the strobe was low with chip select asserted.

Top module: `par_io_core`

## Requirements
- R1: After reset the control register reads 9Bh, every output-enable pin is low, every output latch is zero, and both group modes read as basic (0).
- R2: The register select decodes 00 to port A, 01 to port B, 10 to port C and 11 to control. A write to port A or port B stores the byte in that port's latch whatever the port's direction. A write made while chip select is high changes nothing.
- R3: In a mode command (D7=1), the direction bits are D4 for port A, D3 for the C upper nibble, D1 for port B and D0 for the C lower nibble, with 1 meaning input. Each line's output enable is high exactly when its direction bit is 0.
- R4: A control write with D7=0 sets port C line D3:D1 to the value of D0. It changes no other line. It acts only if that line's nibble is an output, and it acts in any group mode.
- R5: A read of a port returns the live pin for lines programmed as inputs and the output latch for lines programmed as outputs.
- R6: Every mode command clears the latches of ports A, B and C to zero.
- R7: A control read returns the last mode command with D7 read as 1. Single-bit commands leave it unchanged.
- R8: A direct write to port C updates a nibble only when that nibble is an output and its group is in basic mode. Group A is basic when D6:D5=00, and group B is basic when D2=0. Other nibbles keep their latch.
- R9: A write takes effect only after the write strobe returns high. The outputs do not change while the strobe is held low.
- R10: The group A mode output shows control bits D6:D5, and the group B mode output shows D2.
- R11: The data bus output enable is high only while chip select and read are both low. When it is low the data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the bus strobes |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| portSel | input | 2 | Register select |
| dataIn | input | 8 | Bus write data |
| dataOut | output | 8 | Bus read data |
| dataOe | output | 1 | Bus read-data drive enable |
| pinAIn | input | 8 | Port A pin inputs |
| pinAOut | output | 8 | Port A output latch |
| pinAOe | output | 8 | Port A per-line output enable |
| pinBIn | input | 8 | Port B pin inputs |
| pinBOut | output | 8 | Port B output latch |
| pinBOe | output | 8 | Port B per-line output enable |
| pinCIn | input | 8 | Port C pin inputs |
| pinCOut | output | 8 | Port C output latch |
| pinCOe | output | 8 | Port C per-line output enable |
| groupAMode | output | 2 | Group A mode field |
| groupBMode | output | 1 | Group B mode bit |

## Verification
The bench builds the core with its default 8-bit data width, so the 4-bit nibble split and the 3-bit line index of the single-bit command are both exercised in full. Random mode words reach all four direction combinations of port C and all group mode values. This means the nibble guard on direct port C writes is checked against the strobed and bidirectional settings as well as basic mode. Directed cases cover a write strobe held low for several cycles and a write made without chip select.

// File: rtl/parIoPkg.sv
package parIoPkg;
  localparam int DATA_W    = 8;
  localparam int HALF_W    = DATA_W / 2;
  localparam int BIT_IDX_W = $clog2(DATA_W);

  // control word bit positions
  localparam int F_MODE_FLAG = 7;
  localparam int F_A_MODE_HI = 6;
  localparam int F_A_MODE_LO = 5;
  localparam int F_A_DIR     = 4;
  localparam int F_CU_DIR    = 3;
  localparam int F_B_MODE    = 2;
  localparam int F_B_DIR     = 1;
  localparam int F_CL_DIR    = 0;

  localparam logic [DATA_W-1:0] CTRL_RESET = 8'h9B;

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } portSelE;

  typedef struct packed {
    logic              wrA;
    logic              wrB;
    logic              wrC;
    logic              wrMode;
    logic              wrBit;
    logic [DATA_W-1:0] data;
  } cmdStrobeT;
endpackage

// File: rtl/parIoBusCtrl.sv
module parIoBusCtrl
  import parIoPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrN,
  input  logic [1:0]        portSel,
  input  logic [DATA_W-1:0] dataIn,
  output cmdStrobeT         cmd
);
  logic              wrNQ;
  logic              capValid;
  logic [1:0]        capSel;
  logic [DATA_W-1:0] capData;
  logic              commit;

  assign commit = capValid && !wrNQ && wrN;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrNQ     <= 1'b1;
      capValid <= 1'b0;
      capSel   <= '0;
      capData  <= '0;
    end else begin
      wrNQ <= wrN;
      if (!wrN && !csN) begin
        capValid <= 1'b1;
        capSel   <= portSel;
        capData  <= dataIn;
      end else if (commit) begin
        capValid <= 1'b0;
      end
    end
  end

  always_comb begin
    cmd        = '0;
    cmd.data   = capData;
    cmd.wrA    = commit && (capSel == SEL_A);
    cmd.wrB    = commit && (capSel == SEL_B);
    cmd.wrC    = commit && (capSel == SEL_C);
    cmd.wrMode = commit && (capSel == SEL_CTRL) &&  capData[F_MODE_FLAG];
    cmd.wrBit  = commit && (capSel == SEL_CTRL) && !capData[F_MODE_FLAG];
  end

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.wrA, cmd.wrB, cmd.wrC, cmd.wrMode, cmd.wrBit})); // R2

  AST_COMMIT_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    (cmd.wrA || cmd.wrB || cmd.wrC || cmd.wrMode || cmd.wrBit) |-> (wrN && $past(!wrN))); // R9
endmodule

// File: rtl/parIoRegs.sv
module parIoRegs
  import parIoPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cmdStrobeT         cmd,
  input  logic [1:0]        rdSel,
  input  logic [DATA_W-1:0] pinA,
  input  logic [DATA_W-1:0] pinB,
  input  logic [DATA_W-1:0] pinC,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [DATA_W-1:0] latchA,
  output logic [DATA_W-1:0] latchB,
  output logic [DATA_W-1:0] latchC,
  output logic [DATA_W-1:0] cOutMask,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0]    cWrMask;
  logic [DATA_W-1:0]    cNext;
  logic [BIT_IDX_W-1:0] bitIdx;

  // per-nibble direction and direct-write enable for port C
  for (genvar h = 0; h < 2; h++) begin : g_cHalf
    localparam int DirBit = (h == 1) ? F_CU_DIR : F_CL_DIR;
    logic isOut;
    logic isBasic;
    assign isOut = ~ctrlQ[DirBit];
    if (h == 1) begin : g_upper
      assign isBasic = (ctrlQ[F_A_MODE_HI:F_A_MODE_LO] == 2'b00);
    end else begin : g_lower
      assign isBasic = ~ctrlQ[F_B_MODE];
    end
    assign cOutMask[h*HALF_W +: HALF_W] = {HALF_W{isOut}};
    assign cWrMask[h*HALF_W +: HALF_W]  = {HALF_W{isOut & isBasic}};
  end

  assign bitIdx = cmd.data[BIT_IDX_W:1];

  always_comb begin
    cNext = latchC;
    if (cmd.wrC)
      cNext = (latchC & ~cWrMask) | (cmd.data & cWrMask);
    if (cmd.wrBit && cOutMask[bitIdx])
      cNext[bitIdx] = cmd.data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ  <= CTRL_RESET;
      latchA <= '0;
      latchB <= '0;
      latchC <= '0;
    end else if (cmd.wrMode) begin
      ctrlQ  <= cmd.data;
      latchA <= '0;
      latchB <= '0;
      latchC <= '0;
    end else begin
      if (cmd.wrA) latchA <= cmd.data;
      if (cmd.wrB) latchB <= cmd.data;
      latchC <= cNext;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_A:   rdData = ctrlQ[F_A_DIR] ? pinA : latchA;
      SEL_B:   rdData = ctrlQ[F_B_DIR] ? pinB : latchB;
      SEL_C:   rdData = (pinC & ~cOutMask) | (latchC & cOutMask);
      default: rdData = {1'b1, ctrlQ[DATA_W-2:0]};
    endcase
  end

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cmd.wrMode |=> (latchA == '0 && latchB == '0 && latchC == '0)); // R6

  AST_BIT_CMD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmd.wrBit |=> ($countones(latchC ^ $past(latchC)) <= 1)); // R4

  AST_BIT_CMD_KEEPS_CTRL: assert property (@(posedge clk) disable iff (rst)
    cmd.wrBit |=> (ctrlQ == $past(ctrlQ))); // R7

  AST_C_UPPER_GUARD: assert property (@(posedge clk) disable iff (rst)
    (cmd.wrC && (ctrlQ[F_CU_DIR] || ctrlQ[F_A_MODE_HI:F_A_MODE_LO] != 2'b00))
      |=> (latchC[DATA_W-1:HALF_W] == $past(latchC[DATA_W-1:HALF_W]))); // R8

  AST_C_LOWER_GUARD: assert property (@(posedge clk) disable iff (rst)
    (cmd.wrC && (ctrlQ[F_CL_DIR] || ctrlQ[F_B_MODE]))
      |=> (latchC[HALF_W-1:0] == $past(latchC[HALF_W-1:0]))); // R8

  AST_CTRL_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrlQ == CTRL_RESET)); // R1
endmodule

// File: rtl/par_io_core.sv
module par_io_core
  import parIoPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                csN,
  input  logic                rdN,
  input  logic                wrN,
  input  logic [1:0]          portSel,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe,
  input  logic [DATA_W-1:0]   pinAIn,
  output logic [DATA_W-1:0]   pinAOut,
  output logic [DATA_W-1:0]   pinAOe,
  input  logic [DATA_W-1:0]   pinBIn,
  output logic [DATA_W-1:0]   pinBOut,
  output logic [DATA_W-1:0]   pinBOe,
  input  logic [DATA_W-1:0]   pinCIn,
  output logic [DATA_W-1:0]   pinCOut,
  output logic [DATA_W-1:0]   pinCOe,
  output logic [1:0]          groupAMode,
  output logic                groupBMode
);
  cmdStrobeT         cmd;
  logic [DATA_W-1:0] ctrlQ;
  logic [DATA_W-1:0] cOutMask;
  logic [DATA_W-1:0] rdData;

  parIoBusCtrl u_bus (
    .clk     (clk),
    .rst     (rst),
    .csN     (csN),
    .wrN     (wrN),
    .portSel (portSel),
    .dataIn  (dataIn),
    .cmd     (cmd)
  );

  parIoRegs u_regs (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .rdSel    (portSel),
    .pinA     (pinAIn),
    .pinB     (pinBIn),
    .pinC     (pinCIn),
    .ctrlQ    (ctrlQ),
    .latchA   (pinAOut),
    .latchB   (pinBOut),
    .latchC   (pinCOut),
    .cOutMask (cOutMask),
    .rdData   (rdData)
  );

  assign dataOe     = !csN && !rdN;
  assign dataOut    = dataOe ? rdData : '0;
  assign pinAOe     = {DATA_W{~ctrlQ[F_A_DIR]}};
  assign pinBOe     = {DATA_W{~ctrlQ[F_B_DIR]}};
  assign pinCOe     = cOutMask;
  assign groupAMode = ctrlQ[F_A_MODE_HI:F_A_MODE_LO];
  assign groupBMode = ctrlQ[F_B_MODE];

  AST_LINE_OE_GROUPED: assert property (@(posedge clk) disable iff (rst)
    (pinAOe == '0 || pinAOe == '1) && (pinBOe == '0 || pinBOe == '1)); // R3

  AST_C_OE_NIBBLES: assert property (@(posedge clk) disable iff (rst)
    $countones(pinCOe) inside {0, HALF_W, DATA_W}); // R3
endmodule

// File: tb/sim_par_io_core.sv
module sim_par_io_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] portSel = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut, pinAOut, pinAOe, pinBOut, pinBOe, pinCOut, pinCOe;
  logic [7:0] pinAIn = '0, pinBIn = '0, pinCIn = '0;
  logic       dataOe, groupBMode;
  logic [1:0] groupAMode;

  int checks = 0;
  int errors = 0;
  logic [7:0] mCtrl, mA, mB, mC;

  always #5 clk = ~clk;

  par_io_core u0 (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .portSel(portSel),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .pinAIn(pinAIn), .pinAOut(pinAOut), .pinAOe(pinAOe),
    .pinBIn(pinBIn), .pinBOut(pinBOut), .pinBOe(pinBOe),
    .pinCIn(pinCIn), .pinCOut(pinCOut), .pinCOe(pinCOe),
    .groupAMode(groupAMode), .groupBMode(groupBMode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expCOe();
    return {{4{~mCtrl[3]}}, {4{~mCtrl[0]}}};
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] s);
    case (s)
      2'd0:    return mCtrl[4] ? pinAIn : mA;
      2'd1:    return mCtrl[1] ? pinBIn : mB;
      2'd2:    return (pinCIn & ~expCOe()) | (mC & expCOe());
      default: return {1'b1, mCtrl[6:0]};
    endcase
  endfunction

  task automatic modelWrite(input logic [1:0] s, input logic [7:0] d);
    case (s)
      2'd0: mA = d;
      2'd1: mB = d;
      2'd2: begin
        if (mCtrl[6:5] == 2'b00 && !mCtrl[3]) mC[7:4] = d[7:4];
        if (!mCtrl[2] && !mCtrl[0])            mC[3:0] = d[3:0];
      end
      default: begin
        if (d[7]) begin
          mCtrl = d; mA = '0; mB = '0; mC = '0;
        end else begin
          int idx = int'(d[3:1]);
          if ((idx >= 4) ? !mCtrl[3] : !mCtrl[0]) mC[idx] = d[0];
        end
      end
    endcase
  endtask

  task automatic checkPins(input string tag);
    chk({tag, " R2/R6 pinAOut"}, pinAOut, mA);
    chk({tag, " R2/R6 pinBOut"}, pinBOut, mB);
    chk({tag, " R4/R8 pinCOut"}, pinCOut, mC);
    chk({tag, " R3 pinAOe"}, pinAOe, {8{~mCtrl[4]}});
    chk({tag, " R3 pinBOe"}, pinBOe, {8{~mCtrl[1]}});
    chk({tag, " R3 pinCOe"}, pinCOe, expCOe());
    chk({tag, " R10 groupAMode"}, groupAMode, mCtrl[6:5]);
    chk({tag, " R10 groupBMode"}, groupBMode, mCtrl[2]);
  endtask

  task automatic busWrite(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); csN = 1'b0; wrN = 1'b0; portSel = s; dataIn = d;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); csN = 1'b1;
    modelWrite(s, d);
  endtask

  task automatic busRead(input string tag, input logic [1:0] s);
    logic [7:0] e;
    @(negedge clk); csN = 1'b0; rdN = 1'b0; portSel = s;
    #1;
    e = expRead(s);
    chk({tag, " R5/R7 dataOut"}, dataOut, e);
    chk({tag, " R11 dataOe"}, dataOe, 1'b1);
    @(negedge clk); rdN = 1'b1; csN = 1'b1;
    #1;
    chk({tag, " R11 idle"}, {dataOe, dataOut}, 9'h0);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    mCtrl = 8'h9B; mA = '0; mB = '0; mC = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checkPins("R1 reset");
    busRead("R1 reset ctrl", 2'd3);

    // all outputs
    busWrite(2'd3, 8'h80);
    checkPins("R3 all-out");
    busWrite(2'd0, 8'h5A);
    busWrite(2'd1, 8'hC3);
    busWrite(2'd2, 8'h00);
    pinAIn = 8'hFF; pinBIn = 8'h00; pinCIn = 8'hAA;
    checkPins("R2 port writes");
    busRead("R5 out A", 2'd0);
    busRead("R5 out C", 2'd2);

    // R4 single-bit commands
    busWrite(2'd3, 8'h0F);   // line 7 set
    busWrite(2'd3, 8'h05);   // line 2 set
    busWrite(2'd3, 8'h0B);   // line 5 set
    chk("R4 bit cmds", pinCOut, 8'hA4);
    busWrite(2'd3, 8'h0E);   // line 7 clear
    chk("R4 bit clear", pinCOut, 8'h24);
    busRead("R7 ctrl after bit cmds", 2'd3);

    // R2 write without chip select
    @(negedge clk); csN = 1'b1; wrN = 1'b0; portSel = 2'd0; dataIn = 8'h77;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk);
    chk("R2 no-cs write ignored", pinAOut, 8'h5A);

    // R9 strobe held low
    @(negedge clk); csN = 1'b0; wrN = 1'b0; portSel = 2'd0; dataIn = 8'h11;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 held low", pinAOut, 8'h5A);
    end
    wrN = 1'b1;
    @(negedge clk); csN = 1'b1;
    modelWrite(2'd0, 8'h11);
    chk("R9 after release", pinAOut, 8'h11);

    // R6 mode word clears latches
    busWrite(2'd3, 8'h80);
    chk("R6 clear A", pinAOut, 8'h00);
    chk("R6 clear C", pinCOut, 8'h00);

    // R8 guard with group A strobed, group B strobed
    busWrite(2'd3, 8'hA0);
    busWrite(2'd2, 8'hFF);
    chk("R8 upper guarded", pinCOut, 8'h0F);
    busWrite(2'd3, 8'h0D);   // line 6 set in strobed group
    chk("R4 strobed group", pinCOut, 8'h4F);
    busWrite(2'd3, 8'h84);
    busWrite(2'd2, 8'hFF);
    chk("R8 lower guarded", pinCOut, 8'hF0);
    checkPins("R10 modes");

    // R5 inputs and mixed direction
    busWrite(2'd3, 8'h9B);
    pinAIn = 8'h3C; pinBIn = 8'h81; pinCIn = 8'h69;
    busRead("R5 in A", 2'd0);
    busRead("R5 in B", 2'd1);
    busRead("R5 in C", 2'd2);
    busWrite(2'd3, 8'h89);
    busWrite(2'd3, 8'h05);   // input nibble, ignored
    busRead("R4 input nibble", 2'd2);
    checkPins("R3 mixed");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 9));
      logic [7:0] d = 8'($urandom());
      pinAIn = 8'($urandom()); pinBIn = 8'($urandom()); pinCIn = 8'($urandom());
      if (op == 0)       busWrite(2'd3, d | 8'h80);
      else if (op <= 2)  busWrite(2'd3, d & 8'h0F);
      else if (op <= 5)  busWrite(2'($urandom_range(0, 2)), d);
      else               busRead("rand read", 2'($urandom_range(0, 3)));
      checkPins("rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule